// File: doc/BRIEF.md
# Dual-Request Interrupt Router

The block collects a vector of interrupt sources and turns them into two processor request lines and one wake line. Each source has two candidate inputs; a source-select bit picks one of them. The chosen input passes through a two-flop synchroniser and is then judged by a three-bit trigger code. The code picks rising edge, falling edge, both edges, high level, low level or off. Edge events are kept in sticky status registers until software acknowledges them. Level events follow the pin.

Software reaches every control register through a single-cycle bus. Each control register has a set address and a clear address, both write-one. Each control register can also be read back. An enable bit gates a source onto the request lines. A route bit chooses which of the two lines the source drives. A wake-enable bit lets a pending source raise the wake line even when its enable bit is clear. Two read-only views show the masked pending vector of each request line. A scratch test register is also provided.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset (active-low): the route and source-select registers read all ones. Trigger codes, enables, wake enables, both edge status registers and the test register read zero. req0, req1 and wake are low.
- R2: The bus address is {register id[3:0], op[1:0]}. Register ids: 0..2 trigger code bits 0..2, 3 source select, 4 route, 5 wake enable, 6 enable, 7 rising status, 8 falling status, 9 line-0 pending, 10 line-1 pending, 11 test. The read data always shows the register picked by the id field. A write with op 1 to ids 0..6 ORs the write data into that register.
- R3: A write with op 2 to ids 0..6 clears every bit that is 1 in the write data. The same op on ids 7 and 8 acknowledges those status bits.
- R4: A pending, enabled source drives req0 when its route bit is 1 and req1 when its route bit is 0.
- R5: A source whose enable bit is 0 never asserts req0 or req1.
- R6: Trigger code 101 makes a source pending while its selected input is high. Code 110 makes it pending while the input is low. The level reaches the request line on the second clock edge after the input changes.
- R7: Code 001 latches a rising edge and code 010 latches a falling edge, each in its own sticky status register, on the third clock edge after the input changes. The status bit holds until acknowledged. If a detection and an acknowledge for the same bit fall on the same edge, the detection wins.
- R8: Code 011 latches rising edges into the rising status and falling edges into the falling status. The source stays pending until both bits are acknowledged.
- R9: Codes 000, 100 and 111 make a source never pending and never set its status bits.
- R10: A source-select bit of 1 takes the source from irq_a, and 0 takes it from irq_b.
- R11: wake is high exactly when some pending source has its wake-enable bit set, whatever its enable bit.
- R12: Register ids 9 and 10 read the pending vector ANDed with the enables and with route, or with the inverted route, respectively.
- R13: A write with op 3 to id 11 loads the test register, which reads back and has no effect on req0, req1 or wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_a | input | NSRC | Source inputs chosen when source-select is 1 |
| irq_b | input | NSRC | Source inputs chosen when source-select is 0 |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | 6 | {register id, op} |
| bus_wdata | input | NSRC | Write data, one bit per source |
| bus_rdata | output | NSRC | Read data of the register picked by the id field |
| req0 | output | 1 | Request line 0 |
| req1 | output | 1 | Request line 1 |
| wake | output | 1 | Wake line |

## Verification
The bench builds the router with NSRC set to 8 instead of the default 32. With eight sources, random trigger-code writes land on every source often. That puts each mode, the reserved codes, and mode changes over stale status bits within reach in a few hundred cycles. Directed sequences pin down the two-cycle level latency and the three-cycle edge latency. They also cover an acknowledge that lands on the same edge as a detection, both-edge acknowledge order, source selection, and wake with the enable bit clear.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the interrupt router.
// Assumes the bus address is {register id (4 bits), op (2 bits)}.
package irq_pkg;

    localparam int RID_W  = 4;
    localparam int ADDR_W = RID_W + 2;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_LOAD = 2'd3
    } bus_op_e;

    localparam logic [RID_W-1:0] RID_TRIG0 = 4'd0;
    localparam logic [RID_W-1:0] RID_TRIG1 = 4'd1;
    localparam logic [RID_W-1:0] RID_TRIG2 = 4'd2;
    localparam logic [RID_W-1:0] RID_SRC   = 4'd3;
    localparam logic [RID_W-1:0] RID_ROUTE = 4'd4;
    localparam logic [RID_W-1:0] RID_WAKE  = 4'd5;
    localparam logic [RID_W-1:0] RID_EN    = 4'd6;
    localparam logic [RID_W-1:0] RID_RISE  = 4'd7;
    localparam logic [RID_W-1:0] RID_FALL  = 4'd8;
    localparam logic [RID_W-1:0] RID_PND0  = 4'd9;
    localparam logic [RID_W-1:0] RID_PND1  = 4'd10;
    localparam logic [RID_W-1:0] RID_TEST  = 4'd11;

    // Number of set/clear control registers (ids 0..NUM_CTL-1).
    localparam int NUM_CTL = 7;

    typedef struct packed {
        logic rise_en;
        logic fall_en;
        logic lvl_hi;
        logic lvl_lo;
    } trig_dec_t;

    // Turns a three-bit trigger code into mode flags; reserved codes give none.
    function automatic trig_dec_t decode_trig(input logic [2:0] code);
        trig_dec_t d;
        d.rise_en = (code == 3'b001) || (code == 3'b011);
        d.fall_en = (code == 3'b010) || (code == 3'b011);
        d.lvl_hi  = (code == 3'b101);
        d.lvl_lo  = (code == 3'b110);
        return d;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchroniser for a vector of asynchronous inputs.
// Assumes STAGES >= 2; every stage resets to zero.
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
// Control register file with write-one-to-set and write-one-to-clear ops,
// plus the test register and the acknowledge strobes for edge status.
// Assumes at most one bus write per cycle.
module irq_regs
    import irq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   ctl_q [NUM_CTL],
    output logic [NSRC-1:0]   test_q,
    output logic [NSRC-1:0]   ack_rise,
    output logic [NSRC-1:0]   ack_fall
);
    logic [RID_W-1:0] rid;
    bus_op_e          op;

    assign rid = bus_addr[ADDR_W-1:2];
    assign op  = bus_op_e'(bus_addr[1:0]);

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        localparam logic [NSRC-1:0] RST_VAL =
            (g == int'(RID_SRC) || g == int'(RID_ROUTE)) ? '1 : '0;
        localparam logic [RID_W-1:0] MY_ID = RID_W'(g);

        // Apply set or clear writes aimed at this control register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[g] <= RST_VAL;
            end else if (bus_wr && rid == MY_ID) begin
                if (op == OP_SET) begin
                    ctl_q[g] <= ctl_q[g] | bus_wdata;
                end else if (op == OP_CLR) begin
                    ctl_q[g] <= ctl_q[g] & ~bus_wdata;
                end
            end
        end
    end

    // Load the test register on a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= '0;
        end else if (bus_wr && rid == RID_TEST && op == OP_LOAD) begin
            test_q <= bus_wdata;
        end
    end

    // Decode the acknowledge strobes for the sticky status registers.
    always_comb begin
        ack_rise = '0;
        ack_fall = '0;
        if (bus_wr && op == OP_CLR) begin
            if (rid == RID_RISE) ack_rise = bus_wdata;
            if (rid == RID_FALL) ack_fall = bus_wdata;
        end
    end
endmodule

// File: rtl/irq_edge.sv
// Per-source trigger logic: edge detection into sticky status bits and
// level qualification, giving one pending bit per source.
// Assumes lvl is already synchronised to clk.
module irq_edge
    import irq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lvl,
    input  logic [NSRC-1:0] code0,
    input  logic [NSRC-1:0] code1,
    input  logic [NSRC-1:0] code2,
    input  logic [NSRC-1:0] ack_rise,
    input  logic [NSRC-1:0] ack_fall,
    output logic [NSRC-1:0] rise_q,
    output logic [NSRC-1:0] fall_q,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] prev_q;

    // Remember last cycle's synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        trig_dec_t dec;
        assign dec = decode_trig({code2[i], code1[i], code0[i]});

        // Sticky edge status; a new detection outranks an acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_q[i] <= 1'b0;
                fall_q[i] <= 1'b0;
            end else begin
                rise_q[i] <= (rise_q[i] & ~ack_rise[i]) |
                             (dec.rise_en & lvl[i] & ~prev_q[i]);
                fall_q[i] <= (fall_q[i] & ~ack_fall[i]) |
                             (dec.fall_en & ~lvl[i] & prev_q[i]);
            end
        end

        // Pending: status for edge modes, polarity-corrected level otherwise.
        assign pend[i] = (dec.rise_en & rise_q[i]) | (dec.fall_en & fall_q[i]) |
                         (dec.lvl_hi & lvl[i]) | (dec.lvl_lo & ~lvl[i]);
    end
endmodule

// File: rtl/irq_router.sv
// Top of the interrupt router: source selection, synchroniser, trigger
// logic, register file, routing onto two request lines and wake.
// Assumes a single-cycle bus whose read data is combinational.
module irq_router
    import irq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_a,
    input  logic [NSRC-1:0]   irq_b,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              req0,
    output logic              req1,
    output logic              wake
);
    logic [NSRC-1:0] ctl_q [NUM_CTL];
    logic [NSRC-1:0] test_q, ack_rise, ack_fall;
    logic [NSRC-1:0] src_q, route_q, wake_q, en_q;
    logic [NSRC-1:0] raw, lvl, rise_q, fall_q, pend_q, line0, line1;

    irq_regs #(.NSRC(NSRC)) u_regs (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
        .ctl_q, .test_q, .ack_rise, .ack_fall
    );

    assign src_q   = ctl_q[RID_SRC];
    assign route_q = ctl_q[RID_ROUTE];
    assign wake_q  = ctl_q[RID_WAKE];
    assign en_q    = ctl_q[RID_EN];

    // Per-source choice between the two input vectors.
    assign raw = (src_q & irq_a) | (~src_q & irq_b);

    irq_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk, .rst_n, .d(raw), .q(lvl)
    );

    irq_edge #(.NSRC(NSRC)) u_edge (
        .clk, .rst_n, .lvl,
        .code0(ctl_q[RID_TRIG0]), .code1(ctl_q[RID_TRIG1]), .code2(ctl_q[RID_TRIG2]),
        .ack_rise, .ack_fall, .rise_q, .fall_q, .pend(pend_q)
    );

    // Masked pending vectors per request line.
    assign line0 = pend_q & en_q & route_q;
    assign line1 = pend_q & en_q & ~route_q;
    assign req0  = |line0;
    assign req1  = |line1;
    assign wake  = |(pend_q & wake_q);

    // Read mux selected by the register id field.
    always_comb begin
        unique case (bus_addr[ADDR_W-1:2])
            RID_TRIG0, RID_TRIG1, RID_TRIG2, RID_SRC,
            RID_ROUTE, RID_WAKE, RID_EN:
                bus_rdata = ctl_q[bus_addr[ADDR_W-2:2]];
            RID_RISE: bus_rdata = rise_q;
            RID_FALL: bus_rdata = fall_q;
            RID_PND0: bus_rdata = line0;
            RID_PND1: bus_rdata = line1;
            RID_TEST: bus_rdata = test_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_router_chk.sv
// Property checker for the interrupt router, bound to every instance.
// Assumes the bus encoding from irq_pkg.
module irq_router_chk
    import irq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic              req0,
    input logic              req1,
    input logic              wake,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   route_q,
    input logic [NSRC-1:0]   wake_q,
    input logic [NSRC-1:0]   rise_q,
    input logic [NSRC-1:0]   fall_q
);
    a_r5_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (!req0 && !req1));

    a_r4_route_line0: assert property (@(posedge clk) disable iff (!rst_n)
        req0 |-> |(en_q & route_q));

    a_r4_route_line1: assert property (@(posedge clk) disable iff (!rst_n)
        req1 |-> |(en_q & ~route_q));

    a_r11_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> |wake_q);

    a_r7_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == {RID_RISE, OP_CLR}) |=>
        ((rise_q & $past(rise_q)) == $past(rise_q)));

    a_r7_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == {RID_FALL, OP_CLR}) |=>
        ((fall_q & $past(fall_q)) == $past(fall_q)));

    a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == {RID_EN, OP_SET}) |=>
        ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == {RID_EN, OP_CLR}) |=>
        ((en_q & $past(bus_wdata)) == '0));
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .req0(req0), .req1(req1), .wake(wake),
    .en_q(en_q), .route_q(route_q), .wake_q(wake_q),
    .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/sim_irq_router.sv
// Bench: a cycle model written from the requirements, directed corners,
// then seeded random register traffic and input toggling.
module sim_irq_router;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_a = '0, irq_b = '0, bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [N-1:0] bus_rdata;
    logic         req0, req1, wake;

    always #10 clk = ~clk;

    irq_router #(.NSRC(N)) u0 (
        .clk, .rst_n, .irq_a, .irq_b, .bus_wr, .bus_addr, .bus_wdata,
        .bus_rdata, .req0, .req1, .wake
    );

    int checks = 0;
    int errors = 0;

    // Model state: 0..2 trigger bits, 3 select, 4 route, 5 wake, 6 enable.
    logic [N-1:0] m_ctl [7];
    logic [N-1:0] m_test, m_s1, m_s2, m_p, m_rise, m_fall;

    function automatic logic [5:0] A(input int id, input int op);
        return {id[3:0], op[1:0]};
    endfunction

    function automatic logic [2:0] code_of(input int i);
        return {m_ctl[2][i], m_ctl[1][i], m_ctl[0][i]};
    endfunction

    function automatic logic [N-1:0] exp_pend();
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) begin
            logic [2:0] c;
            c = code_of(i);
            p[i] = ((c == 3'b001 || c == 3'b011) && m_rise[i]) ||
                   ((c == 3'b010 || c == 3'b011) && m_fall[i]) ||
                   (c == 3'b101 && m_s2[i]) || (c == 3'b110 && !m_s2[i]);
        end
        return p;
    endfunction

    function automatic logic [N-1:0] mread(input int id);
        case (id)
            0, 1, 2, 3, 4, 5, 6: return m_ctl[id];
            7:  return m_rise;
            8:  return m_fall;
            9:  return exp_pend() & m_ctl[6] & m_ctl[4];
            10: return exp_pend() & m_ctl[6] & ~m_ctl[4];
            11: return m_test;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 7; k++) m_ctl[k] = (k == 3 || k == 4) ? '1 : '0;
        m_test = '0; m_s1 = '0; m_s2 = '0; m_p = '0; m_rise = '0; m_fall = '0;
    endtask

    task automatic model_edge(input logic w, input logic [5:0] a, input logic [N-1:0] d);
        logic [N-1:0] re, fe, ack_r, ack_f;
        int rid, op;
        rid = int'(a[5:2]);
        op  = int'(a[1:0]);
        for (int i = 0; i < N; i++) begin
            re[i] = (code_of(i) == 3'b001) || (code_of(i) == 3'b011);
            fe[i] = (code_of(i) == 3'b010) || (code_of(i) == 3'b011);
        end
        ack_r = (w && rid == 7 && op == 2) ? d : '0;
        ack_f = (w && rid == 8 && op == 2) ? d : '0;
        m_rise = (m_rise & ~ack_r) | (m_s2 & ~m_p & re);
        m_fall = (m_fall & ~ack_f) | (~m_s2 & m_p & fe);
        m_p  = m_s2;
        m_s2 = m_s1;
        m_s1 = (m_ctl[3] & irq_a) | (~m_ctl[3] & irq_b);
        if (w) begin
            if (rid < 7 && op == 1) m_ctl[rid] = m_ctl[rid] | d;
            if (rid < 7 && op == 2) m_ctl[rid] = m_ctl[rid] & ~d;
            if (rid == 11 && op == 3) m_test = d;
        end
    endtask

    // One clock: drive the bus, update the model at the edge, check outputs.
    task automatic tick(input logic w, input logic [5:0] a, input logic [N-1:0] d);
        logic [N-1:0] p;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (rst_n) model_edge(w, a, d);
        else       model_reset();
        @(negedge clk);
        bus_wr = 1'b0;
        p = exp_pend();
        check("R4 req0", N'(req0), N'(|(p & m_ctl[6] & m_ctl[4])));
        check("R4 req1", N'(req1), N'(|(p & m_ctl[6] & ~m_ctl[4])));
        check("R11 wake", N'(wake), N'(|(p & m_ctl[5])));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 6'd0, '0);
    endtask

    task automatic rd(input string tag, input int id);
        bus_addr = A(id, 0);
        #1;
        check(tag, bus_rdata, mread(id));
    endtask

    function automatic string tag_of(input int id);
        if (id == 9 || id == 10) return "R12 pending view";
        if (id == 7 || id == 8)  return "R7 status";
        if (id == 11)            return "R13 test";
        return "R2 control";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;

        // R1: reset values.
        for (int id = 0; id < 12; id++) rd("R1 reset", id);
        bus_addr = A(4, 0); #1; check("R1 route ones", bus_rdata, '1);
        bus_addr = A(6, 0); #1; check("R1 enable zero", bus_rdata, '0);
        check("R1 outputs", N'({req0, req1, wake}), '0);

        // R2 / R3: set and clear on the enable register.
        tick(1'b1, A(6, 1), 8'h0F);
        tick(1'b1, A(6, 1), 8'hF0);
        bus_addr = A(6, 0); #1; check("R2 set ORs", bus_rdata, 8'hFF);
        tick(1'b1, A(6, 2), 8'h3C);
        bus_addr = A(6, 0); #1; check("R3 clear", bus_rdata, 8'hC3);
        tick(1'b1, A(6, 2), 8'hFF);

        // R6: high level on source 0, two-edge latency.
        tick(1'b1, A(0, 1), 8'h01);
        tick(1'b1, A(2, 1), 8'h01);
        tick(1'b1, A(6, 1), 8'h01);
        irq_a[0] = 1'b1;
        idle(1); check("R6 not yet", N'(req0), '0);
        idle(1); check("R6 high level", N'(req0), 8'h01);
        // R6: low level (110) with input high -> not pending.
        tick(1'b1, A(1, 1), 8'h01);
        tick(1'b1, A(0, 2), 8'h01);
        check("R6 low level idle", N'(req0), '0);
        irq_a[0] = 1'b0;
        idle(2); check("R6 low level active", N'(req0), 8'h01);
        tick(1'b1, A(6, 2), 8'h01);
        check("R5 masked", N'({req0, req1}), '0);

        // R7: rising edge on source 1; acknowledge on the detection edge.
        tick(1'b1, A(0, 1), 8'h02);
        tick(1'b1, A(6, 1), 8'h02);
        irq_a[1] = 1'b1;
        idle(2);
        tick(1'b1, A(7, 2), 8'h02);
        bus_addr = A(7, 0); #1; check("R7 detect wins", bus_rdata & 8'h02, 8'h02);
        irq_a[1] = 1'b0;
        idle(3); check("R7 sticky", N'(req0), 8'h01);
        tick(1'b1, A(7, 2), 8'h02);
        check("R7 acknowledged", N'(req0), '0);

        // R8: both edges on source 2.
        tick(1'b1, A(0, 1), 8'h04);
        tick(1'b1, A(1, 1), 8'h04);
        tick(1'b1, A(6, 1), 8'h04);
        irq_a[2] = 1'b1; idle(3);
        irq_a[2] = 1'b0; idle(3);
        bus_addr = A(7, 0); #1; check("R8 rise status", bus_rdata & 8'h04, 8'h04);
        bus_addr = A(8, 0); #1; check("R8 fall status", bus_rdata & 8'h04, 8'h04);
        tick(1'b1, A(7, 2), 8'h04);
        check("R8 one left", N'(req0), 8'h01);
        tick(1'b1, A(8, 2), 8'h04);
        check("R8 both acked", N'(req0), '0);

        // R9: reserved codes 111 and 100 on source 3.
        tick(1'b1, A(0, 1), 8'h08);
        tick(1'b1, A(1, 1), 8'h08);
        tick(1'b1, A(2, 1), 8'h08);
        tick(1'b1, A(6, 1), 8'h08);
        irq_a[3] = 1'b1; idle(3); check("R9 code 111", N'(req0), '0);
        irq_a[3] = 1'b0; idle(3);
        bus_addr = A(7, 0); #1; check("R9 no status", bus_rdata & 8'h08, '0);
        tick(1'b1, A(0, 2), 8'h08);
        tick(1'b1, A(1, 2), 8'h08);
        irq_a[3] = 1'b1; idle(3); check("R9 code 100", N'(req0), '0);

        // R10: source select on source 4, then R4 routing and R11 wake.
        tick(1'b1, A(3, 2), 8'h10);
        tick(1'b1, A(0, 1), 8'h10);
        tick(1'b1, A(2, 1), 8'h10);
        tick(1'b1, A(6, 1), 8'h10);
        irq_a[4] = 1'b1; idle(3); check("R10 ignores irq_a", N'(req0), '0);
        irq_b[4] = 1'b1; idle(3); check("R10 takes irq_b", N'(req0), 8'h01);
        tick(1'b1, A(4, 2), 8'h10);
        check("R4 to line 1", N'({req0, req1}), 8'h01);
        rd("R12 line 1 view", 10);
        tick(1'b1, A(6, 2), 8'h10);
        tick(1'b1, A(5, 1), 8'h10);
        check("R11 wake unmasked", N'({req1, wake}), 8'h01);

        // R13: test register load has no effect on outputs.
        tick(1'b1, A(11, 3), 8'hA5);
        bus_addr = A(11, 0); #1; check("R13 readback", bus_rdata, 8'hA5);

        // Seeded random traffic checked against the model every cycle.
        void'($urandom(32'd2024));
        for (int it = 0; it < 1500; it++) begin
            int r, id;
            r = int'($urandom % 8);
            if ($urandom % 3 == 0) irq_a = N'($urandom);
            if ($urandom % 4 == 0) irq_b = N'($urandom);
            if (r < 5) begin
                id = int'($urandom % 9);
                tick(1'b1, A(id, 1 + int'($urandom % 2)), N'($urandom));
            end else if (r == 5) begin
                tick(1'b1, A(11, 3), N'($urandom));
            end else begin
                idle(1);
            end
            id = int'($urandom % 13);
            rd(tag_of(id), id);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule